// File: doc/BRIEF.md
# Gated Timebase Counter with Selectable Clock Source

This block is a free-running timebase counter for a timer subsystem. Its count source is set by a mode input. In gated mode, an internal tick at one eighth of the system clock advances the counter only while the external pin is high. In external mode, the pin is synchronized and debounced, and each rising edge of the cleaned level is one count event. A 2-bit prescaler code then divides the chosen source by 1, 2, 4 or 8.

Everything runs on the one system clock. The divider, the gate and the edge detector each give a one-cycle enable pulse; none of them makes a derived clock. A stop request freezes the divider, the prescaler and the counter, and a status flag reports the halt. When the request is removed, counting resumes with the phase it had when it stopped. Reset is synchronous and active high.

There is no data stream here. Every port is a plain control or status pin, so no valid/ready handshake or back-pressure applies.

Top module: `gtb_timebase`

## Requirements
- R1: While reset is high, `count` reads 0 and `stop_flag` reads 0.
- R2: In gated mode (`gate_mode` = 1) with the pin held high, `count` rises by one every 8·2^k system clocks, where k is the value of `presc_sel` (00→8, 01→16, 10→32, 11→64). The first increment comes exactly one period after reset is released.
- R3: In gated mode, the pin passes through a two-flop synchronizer. Internal ticks that arrive while the synchronized pin is low are dropped and do not change the count.
- R4: In external mode (`gate_mode` = 0), each accepted rising edge of the pin is one source event, and `count` rises once per 2^k events. Edges at least nine system clocks apart are all counted.
- R5: The pin filter accepts a new level only after the synchronized pin has held that level for 3 consecutive system clocks. High pulses of 1 or 2 clocks make no count, and a 3-clock pulse makes one.
- R6: While `stop_req` is high, `count` holds its value. `stop_flag` goes high on the first clock edge that samples `stop_req` high.
- R7: After `stop_req` drops, `stop_flag` goes low on the next clock edge. Counting then resumes from the held value with the divider and prescaler phase it had before the stop.
- R8: A new `presc_sel` value is taken up only when the current prescaler period finishes. The period in progress keeps the old ratio.
- R9: The counter wraps from its all-ones value to 0.
- R10: `count` never moves by anything other than 0 or +1 (modulo 2^CNT_W) between two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_pin | input | 1 | External pin: gate in gated mode, count source in external mode |
| gate_mode | input | 1 | 1 = gated divided-by-8 source, 0 = filtered external edges |
| presc_sel | input | 2 | Prescaler code, ratio 2^code |
| stop_req | input | 1 | Freeze request |
| count | output | CNT_W | Timebase counter value |
| stop_flag | output | 1 | High while the block is halted |

## Verification
The bench builds the block with CNT_W = 6 and keeps the divider, filter and synchronizer depths at their defaults. With a 6-bit counter, wrap-around happens after 512 gated cycles at prescaler code 00, so R9 can be reached in a short run. Every period, filter and phase check then uses the same timing as a 16-bit build.

// File: rtl/gtb_pkg.sv
package gtb_pkg;
  parameter int unsigned GTB_PRE_W = 2;
  localparam int unsigned GTB_PHASE_W = (1 << GTB_PRE_W) - 1;

  typedef logic [GTB_PRE_W-1:0]   presc_t;
  typedef logic [GTB_PHASE_W-1:0] phase_t;

  // last prescaler phase before rollover for a ratio of 2^code
  function automatic phase_t gtb_last_phase(presc_t code);
    int unsigned span;
    span = (32'd1 << code) - 32'd1;
    return phase_t'(span);
  endfunction
endpackage

// File: rtl/gtb_pin_cond.sv
module gtb_pin_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic pin_sync,
  output logic filt_rise
);
  localparam int unsigned RUN_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b0;
    else     sh[0] <= pin_raw;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sh[s] <= 1'b0;
        else     sh[s] <= sh[s-1];
      end
    end
  endgenerate

  assign pin_sync = sh[SYNC_STAGES-1];

  logic             lvl;
  logic [RUN_W-1:0] run;
  logic             accept;

  assign accept = (pin_sync != lvl) && (run == RUN_W'(FILT_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl       <= 1'b0;
      run       <= '0;
      filt_rise <= 1'b0;
    end else begin
      filt_rise <= accept && pin_sync;
      if (pin_sync == lvl) begin
        run <= '0;
      end else if (accept) begin
        lvl <= pin_sync;
        run <= '0;
      end else begin
        run <= run + RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/gtb_tick_src.sv
module gtb_tick_src #(
  parameter int unsigned DIV_BASE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic gate_mode,
  input  logic pin_sync,
  input  logic filt_rise,
  output logic src_tick
);
  localparam int unsigned DIV_W = (DIV_BASE > 2) ? $clog2(DIV_BASE) : 1;

  logic [DIV_W-1:0] div_q;
  logic             div_wrap;

  assign div_wrap = (div_q == DIV_W'(DIV_BASE - 1));

  always_ff @(posedge clk) begin
    if (rst)        div_q <= '0;
    else if (!hold) div_q <= div_wrap ? '0 : div_q + DIV_W'(1);
  end

  always_comb begin
    if (hold)           src_tick = 1'b0;
    else if (gate_mode) src_tick = div_wrap && pin_sync;
    else                src_tick = filt_rise;
  end
endmodule

// File: rtl/gtb_prescaler.sv
module gtb_prescaler
  import gtb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hold,
  input  logic   src_tick,
  input  presc_t presc_sel,
  output logic   cnt_en
);
  presc_t active;
  phase_t phase;
  logic   last;

  assign last   = (phase == gtb_last_phase(active));
  assign cnt_en = src_tick && !hold && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= presc_sel;
      phase  <= '0;
    end else if (src_tick && !hold) begin
      if (last) begin
        phase  <= '0;
        active <= presc_sel;
      end else begin
        phase <= phase + phase_t'(1);
      end
    end
  end
endmodule

// File: rtl/gtb_timebase.sv
module gtb_timebase
  import gtb_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DIV_BASE    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ext_pin,
  input  logic                 gate_mode,
  input  logic [GTB_PRE_W-1:0] presc_sel,
  input  logic                 stop_req,
  output logic [CNT_W-1:0]     count,
  output logic                 stop_flag
);
  logic pin_sync;
  logic filt_rise;
  logic src_tick;
  logic cnt_en;

  gtb_pin_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_pin (
    .clk(clk), .rst(rst), .pin_raw(ext_pin),
    .pin_sync(pin_sync), .filt_rise(filt_rise)
  );

  gtb_tick_src #(.DIV_BASE(DIV_BASE)) u_src (
    .clk(clk), .rst(rst), .hold(stop_req), .gate_mode(gate_mode),
    .pin_sync(pin_sync), .filt_rise(filt_rise), .src_tick(src_tick)
  );

  gtb_prescaler u_pre (
    .clk(clk), .rst(rst), .hold(stop_req), .src_tick(src_tick),
    .presc_sel(presc_sel), .cnt_en(cnt_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      stop_flag <= 1'b0;
    end else begin
      stop_flag <= stop_req;
      if (cnt_en) count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/gtb_timebase_chk.sv
module gtb_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_pin,
  input logic             gate_mode,
  input logic             stop_req,
  input logic [CNT_W-1:0] count,
  input logic             stop_flag
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == CNT_W'($past(count) + CNT_W'(1)))); // R10

  AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stop_flag == $past(stop_req))); // R6

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stop_flag |-> $stable(count)); // R6

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ($past(gate_mode) && !$past(ext_pin, 3) && !$past(rst, 3)) |-> $stable(count)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && !stop_flag)); // R1
endmodule

bind gtb_timebase gtb_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ext_pin(ext_pin), .gate_mode(gate_mode),
  .stop_req(stop_req), .count(count), .stop_flag(stop_flag)
);

// File: tb/sim_gtb_timebase.sv
`timescale 1ns/1ps
module sim_gtb_timebase;
  localparam int unsigned CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_pin = 1'b0;
  logic          gate_mode = 1'b1;
  logic [1:0]    presc_sel = 2'b00;
  logic          stop_req = 1'b0;
  logic [CW-1:0] count;
  logic          stop_flag;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gtb_timebase #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .gate_mode(gate_mode),
    .presc_sel(presc_sel), .stop_req(stop_req), .count(count), .stop_flag(stop_flag)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic [1:0] code, input logic pin);
    gate_mode = mode; presc_sel = code; ext_pin = pin; stop_req = 1'b0;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; stop_req = 1'b1; ext_pin = 1'b1;
    step(4);
    chk("R1 count", int'(count), 0);
    chk("R1 flag", int'(stop_flag), 0);
    stop_req = 1'b0;
  endtask

  task automatic t_gated_rates();
    for (int k = 0; k < 4; k++) begin
      int p;
      p = 8 << k;
      do_reset(1'b1, 2'(k), 1'b1);
      step(p - 1);
      chk("R2 before first", int'(count), 0);
      step(1);
      chk("R2 first period", int'(count), 1);
      step(2 * p - 1);
      chk("R2 before third", int'(count), 2);
      step(1);
      chk("R2 third period", int'(count), 3);
    end
  endtask

  task automatic t_gate_low();
    do_reset(1'b1, 2'b00, 1'b0);
    step(40);
    chk("R3 pin low", int'(count), 0);
    ext_pin = 1'b1;
    step(8);
    chk("R3 pin raised", int'(count), 1);
    ext_pin = 1'b0;
    step(20);
    chk("R3 pin lowered", int'(count), 1);
  endtask

  task automatic pulse(input int hi, input int lo);
    ext_pin = 1'b1; step(hi);
    ext_pin = 1'b0; step(lo);
  endtask

  task automatic t_external();
    do_reset(1'b0, 2'b00, 1'b0);
    for (int i = 0; i < 5; i++) pulse(6, 6);
    step(10);
    chk("R4 ext div1", int'(count), 5);
    do_reset(1'b0, 2'b01, 1'b0);
    for (int i = 0; i < 6; i++) pulse(5, 5);
    step(10);
    chk("R4 ext div2", int'(count), 3);
  endtask

  task automatic t_filter();
    do_reset(1'b0, 2'b00, 1'b0);
    pulse(1, 10);
    chk("R5 one-clock glitch", int'(count), 0);
    pulse(2, 10);
    chk("R5 two-clock glitch", int'(count), 0);
    pulse(3, 10);
    chk("R5 three-clock pulse", int'(count), 1);
  endtask

  task automatic t_stop();
    do_reset(1'b1, 2'b00, 1'b1);
    step(12);
    chk("R6 pre-stop", int'(count), 1);
    stop_req = 1'b1;
    step(1);
    chk("R6 flag set", int'(stop_flag), 1);
    step(50);
    chk("R6 held", int'(count), 1);
    chk("R6 flag held", int'(stop_flag), 1);
    stop_req = 1'b0;
    step(1);
    chk("R7 flag clear", int'(stop_flag), 0);
    step(2);
    chk("R7 phase kept", int'(count), 1);
    step(1);
    chk("R7 resumed", int'(count), 2);
  endtask

  task automatic t_presc_change();
    do_reset(1'b1, 2'b11, 1'b1);
    step(70);
    chk("R8 first slow period", int'(count), 1);
    presc_sel = 2'b00;
    step(57);
    chk("R8 old ratio kept", int'(count), 1);
    step(1);
    chk("R8 rollover", int'(count), 2);
    step(7);
    chk("R8 before new", int'(count), 2);
    step(1);
    chk("R8 new ratio", int'(count), 3);
  endtask

  task automatic t_wrap();
    do_reset(1'b1, 2'b00, 1'b1);
    step(511);
    chk("R9 all ones", int'(count), (1 << CW) - 1);
    step(1);
    chk("R9 wrapped", int'(count), 0);
    step(8);
    chk("R9 after wrap", int'(count), 1);
  endtask

  initial begin
    step(2);
    t_reset();
    t_gated_rates();
    t_gate_low();
    t_external();
    t_filter();
    t_stop();
    t_presc_change();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule